// File: doc/BRIEF.md
# Sequencer Trigger Arbiter

This block chooses which of four sample sequencers the converter runs next. Software sets a 2-bit rank for each sequencer in a priority register. It starts sequencers by writing a mask to a write-only initiate register. A per-sequencer enable input gates each start request. A request that is accepted is remembered as pending until it is serviced.

While no sequence is running, the arbiter looks at every pending request whose sequencer is still enabled. It grants the one with the smallest rank value. The grant is a level: `grant_valid` stays high and `grant_id` stays fixed until the converter pulses `conv_done`. A running sequence is never preempted. The grant acts as a valid signal without back-pressure, and `conv_done` is its only release. A `conv_done` pulse is ignored while no grant is held.

Register access is a single-cycle write strobe with a one-bit register select. Select 0 is the priority register and select 1 is the initiate register. Reads are combinational on the select.

Top module: `seq_trigger_arbiter`

## Requirements
- R1: After reset, the priority register reads 0x0000_3210 and `grant_valid` is low.
- R2: The priority register holds the rank of sequencer n in bits [4n+1:4n], for n = 0..3. All other bits read as 0, and any value written to those bits is dropped.
- R3: A read with select 1 (the initiate register) always returns 0.
- R4: Writing select 1 with bit n set makes sequencer n pending, but only if `seq_enable[n]` is high during that write. A trigger for a disabled sequencer is dropped and is never granted later.
- R5: When no grant is held and at least one pending sequencer is enabled, `grant_valid` rises on the next clock edge with `grant_id` set to the sequencer whose rank value is smallest (0 is best). After an initiate write on edge T, the grant is visible after edge T+1. The granted request is removed from the pending set.
- R6: Sequencers triggered in one write are granted one after another, in the order of their programmed ranks.
- R7: When ranks are equal, the lower-numbered sequencer is granted first.
- R8: `grant_valid` and `grant_id` hold steady until `conv_done` is seen high while a grant is held. The grant then drops on that edge, and the next grant can appear one edge later at the earliest.
- R9: A trigger for a sequencer that is already pending merges into the existing request, so the sequencer is granted only once.
- R10: A trigger that arrives while a grant is held waits for the grant to be released, even if its rank is better.
- R11: A pending sequencer whose enable is low is skipped. It keeps its request and is granted once its enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 priority, 1 initiate |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| seq_enable | input | 4 | Per-sequencer enable |
| conv_done | input | 1 | Converter reports the running sequence has finished |
| grant_valid | output | 1 | A sequencer is granted and running |
| grant_id | output | 2 | Index of the granted sequencer |

## Verification
If a pending bit is lost or stuck, it shows up at `grant_valid` within two cycles of the next release. Either a grant that should come never arrives, or an extra grant appears for a sequence that was already serviced. A wrong rank comparison shows up in the first grant after a multi-bit initiate, because `grant_id` then names the wrong sequencer. A broken hold path shows up as `grant_id` changing, or `grant_valid` dropping, in a cycle with no `conv_done`. Priority field placement and the reserved bits can be seen on `reg_rdata` right after a write.

// File: rtl/seqarb_pkg.sv
package seqarb_pkg;
  localparam int unsigned SEQ_COUNT = 4;
  localparam int unsigned RANK_BITS = 2;
  localparam int unsigned DATA_BITS = 32;
  localparam int unsigned RANK_STRIDE = 4;

  typedef enum logic {
    SEL_RANK     = 1'b0,
    SEL_INITIATE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/seqarb_regs.sv
module seqarb_regs
  import seqarb_pkg::*;
#(
  parameter int unsigned NSEQ   = SEQ_COUNT,
  parameter int unsigned RW     = RANK_BITS,
  parameter int unsigned DW     = DATA_BITS,
  parameter int unsigned STRIDE = RANK_STRIDE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   sel,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NSEQ-1:0]        enable,
  output logic [NSEQ-1:0][RW-1:0] rank,
  output logic [NSEQ-1:0]        trig
);
  logic [NSEQ-1:0][RW-1:0] rank_q;
  logic [DW-1:0]           rank_view;

  // one rank field per sequencer; reset rank equals the index
  for (genvar g = 0; g < NSEQ; g++) begin : g_rank
    localparam int unsigned LSB = g * STRIDE;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rank_q[g] <= RW'(g);
      else if (wr && sel == SEL_RANK)
        rank_q[g] <= wdata[LSB +: RW];
    end
  end

  always_comb begin
    rank_view = '0;
    for (int i = 0; i < NSEQ; i++)
      rank_view[i*STRIDE +: RW] = rank_q[i];
  end

  assign rdata = (sel == SEL_RANK) ? rank_view : '0;
  assign rank  = rank_q;
  assign trig  = (wr && sel == SEL_INITIATE) ? (wdata[NSEQ-1:0] & enable) : '0;
endmodule

// File: rtl/seqarb_pick.sv
module seqarb_pick #(
  parameter int unsigned NSEQ = 4,
  parameter int unsigned RW   = 2,
  localparam int unsigned IDW = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
  input  logic [NSEQ-1:0]         eligible,
  input  logic [NSEQ-1:0][RW-1:0] rank,
  output logic                    found,
  output logic [IDW-1:0]          pick_id
);
  logic [RW-1:0] best_rank;

  // strict less-than keeps the lower index on equal ranks
  always_comb begin
    found     = 1'b0;
    pick_id   = '0;
    best_rank = '1;
    for (int i = 0; i < NSEQ; i++) begin
      if (eligible[i] && (!found || rank[i] < best_rank)) begin
        found     = 1'b1;
        pick_id   = IDW'(i);
        best_rank = rank[i];
      end
    end
  end
endmodule

// File: rtl/seqarb_grant.sv
module seqarb_grant #(
  parameter int unsigned NSEQ = 4,
  parameter int unsigned RW   = 2,
  localparam int unsigned IDW = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSEQ-1:0]         trig,
  input  logic [NSEQ-1:0]         enable,
  input  logic [NSEQ-1:0][RW-1:0] rank,
  input  logic                    conv_done,
  output logic                    grant_valid,
  output logic [IDW-1:0]          grant_id
);
  logic [NSEQ-1:0] pending_q;
  logic [NSEQ-1:0] taken;
  logic            found;
  logic [IDW-1:0]  pick_id;
  logic            take;
  logic            valid_q;
  logic [IDW-1:0]  id_q;

  seqarb_pick #(.NSEQ(NSEQ), .RW(RW)) u_pick (
    .eligible (pending_q & enable),
    .rank     (rank),
    .found    (found),
    .pick_id  (pick_id)
  );

  assign take  = !valid_q && found;
  assign taken = take ? (NSEQ'(1) << pick_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      valid_q   <= 1'b0;
      id_q      <= '0;
    end else begin
      pending_q <= (pending_q & ~taken) | trig;
      if (valid_q && conv_done) begin
        valid_q <= 1'b0;
      end else if (take) begin
        valid_q <= 1'b1;
        id_q    <= pick_id;
      end
    end
  end

  assign grant_valid = valid_q;
  assign grant_id    = id_q;
endmodule

// File: rtl/seq_trigger_arbiter.sv
module seq_trigger_arbiter
  import seqarb_pkg::*;
#(
  parameter int unsigned NSEQ   = SEQ_COUNT,
  parameter int unsigned RW     = RANK_BITS,
  parameter int unsigned DW     = DATA_BITS,
  parameter int unsigned STRIDE = RANK_STRIDE,
  localparam int unsigned IDW   = (NSEQ > 1) ? $clog2(NSEQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSEQ-1:0] seq_enable,
  input  logic            conv_done,
  output logic            grant_valid,
  output logic [IDW-1:0]  grant_id
);
  logic [NSEQ-1:0][RW-1:0] rank;
  logic [NSEQ-1:0]         trig;

  seqarb_regs #(.NSEQ(NSEQ), .RW(RW), .DW(DW), .STRIDE(STRIDE)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .enable (seq_enable),
    .rank   (rank),
    .trig   (trig)
  );

  seqarb_grant #(.NSEQ(NSEQ), .RW(RW)) u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig        (trig),
    .enable      (seq_enable),
    .rank        (rank),
    .conv_done   (conv_done),
    .grant_valid (grant_valid),
    .grant_id    (grant_id)
  );
endmodule

// File: rtl/seq_trigger_arbiter_chk.sv
module seq_trigger_arbiter_chk #(
  parameter int unsigned NSEQ = 4,
  parameter int unsigned DW   = 32,
  parameter int unsigned IDW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_sel,
  input logic [DW-1:0]   reg_rdata,
  input logic [NSEQ-1:0] seq_enable,
  input logic            conv_done,
  input logic            grant_valid,
  input logic [IDW-1:0]  grant_id
);
  logic [NSEQ-1:0] en_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else        en_q <= seq_enable;

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !conv_done |=> grant_valid && $stable(grant_id)); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && conv_done |=> !grant_valid); // R8

  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> en_q[grant_id]); // R11

  AST_INIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> reg_rdata == '0); // R3

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~DW'(32'h0000_3333)) == '0); // R2
endmodule

bind seq_trigger_arbiter seq_trigger_arbiter_chk #(.NSEQ(NSEQ), .DW(DW), .IDW(IDW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_rdata   (reg_rdata),
  .seq_enable  (seq_enable),
  .conv_done   (conv_done),
  .grant_valid (grant_valid),
  .grant_id    (grant_id)
);

// File: tb/seq_trigger_arbiter_tb_top.sv
module seq_trigger_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  seq_enable = 4'hF;
  logic        conv_done = 1'b0;
  logic        grant_valid;
  logic [1:0]  grant_id;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  seq_trigger_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_enable(seq_enable),
    .conv_done(conv_done), .grant_valid(grant_valid), .grant_id(grant_id)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic sel, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic read_reg(logic sel, output logic [31:0] data);
    @(negedge clk);
    reg_sel = sel;
    #1 data = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // grant expected at the negedge after the write returns (edge T+1)
  task automatic expect_grant(string req, logic [1:0] id);
    @(negedge clk);
    check({req, " valid"}, {31'b0, grant_valid}, 32'd1);
    check({req, " id"}, {30'b0, grant_id}, {30'b0, id});
  endtask

  task automatic release_grant(string req);
    @(negedge clk);
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    check({req, " released"}, {31'b0, grant_valid}, 32'd0);
  endtask

  task automatic expect_idle(string req, int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (grant_valid) seen = 1'b1;
    end
    check({req, " idle"}, {31'b0, seen}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    read_reg(1'b0, d);
    check("R1 rank reset", d, 32'h0000_3210);
    check("R1 no grant", {31'b0, grant_valid}, 32'd0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    write_reg(1'b0, 32'hFFFF_FFFF);
    read_reg(1'b0, d);
    check("R2 reserved dropped", d, 32'h0000_3333);
    write_reg(1'b0, 32'h0000_1203);
    read_reg(1'b0, d);
    check("R2 field place", d, 32'h0000_1203);
    read_reg(1'b1, d);
    check("R3 initiate reads 0", d, 32'h0);
    write_reg(1'b0, 32'h0000_3210);
  endtask

  task automatic t_single;
    write_reg(1'b1, 32'h4);
    expect_grant("R5 single", 2'd2);
    repeat (3) @(negedge clk);
    check("R8 hold id", {30'b0, grant_id}, 32'd2);
    check("R8 hold valid", {31'b0, grant_valid}, 32'd1);
    release_grant("R8");
    expect_idle("R5 pending cleared", 4);
  endtask

  task automatic t_order;
    write_reg(1'b0, 32'h0000_0123);
    write_reg(1'b1, 32'hF);
    expect_grant("R6 first", 2'd3);
    release_grant("R6");
    expect_grant("R6 second", 2'd2);
    release_grant("R6");
    expect_grant("R6 third", 2'd1);
    release_grant("R6");
    expect_grant("R6 fourth", 2'd0);
    release_grant("R6");
    expect_idle("R6 done", 3);
  endtask

  task automatic t_tie;
    write_reg(1'b0, 32'h0000_1001);
    write_reg(1'b1, 32'h6);
    expect_grant("R7 tie low index", 2'd1);
    release_grant("R7");
    expect_grant("R7 tie next", 2'd2);
    release_grant("R7");
    write_reg(1'b0, 32'h0000_3210);
  endtask

  task automatic t_disabled;
    seq_enable = 4'b1011;
    write_reg(1'b1, 32'h4);
    expect_idle("R4 disabled drop", 5);
    seq_enable = 4'hF;
    expect_idle("R4 not revived", 5);
  endtask

  task automatic t_nopreempt_merge;
    write_reg(1'b1, 32'h8);
    expect_grant("R10 low rank runs", 2'd3);
    write_reg(1'b1, 32'h1);
    write_reg(1'b1, 32'h1);
    repeat (2) @(negedge clk);
    check("R10 not preempted", {30'b0, grant_id}, 32'd3);
    release_grant("R10");
    expect_grant("R10 waiter", 2'd0);
    release_grant("R9");
    expect_idle("R9 merged once", 5);
  endtask

  task automatic t_skip_disabled;
    write_reg(1'b1, 32'h2);
    expect_grant("R11 runner", 2'd1);
    write_reg(1'b1, 32'h1);
    seq_enable = 4'b1110;
    release_grant("R11");
    expect_idle("R11 skipped", 4);
    seq_enable = 4'hF;
    @(negedge clk);
    expect_grant("R11 revived", 2'd0);
    release_grant("R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_single();
    t_order();
    t_tie();
    t_disabled();
    t_nopreempt_merge();
    t_skip_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule